// File: doc/BRIEF.md
# Cache Victim Way Selector

This block picks the way to evict from one set of a 64-way set-associative cache each time a line fill starts. Each line is eight words long, and every fill asks for exactly one victim. A one-cycle request strobe starts a selection. On the next cycle the block presents either a valid way index or, when every way is locked, a no-victim flag.

Two replacement policies are available, and the choice can be changed between any two requests. The round-robin policy walks through the unlocked ways in order. The pseudo-random policy folds a free-running linear feedback shift register into the range of unlocked ways. A lock-down base value L reserves ways 0 to L-1 so that time-critical lines stay resident. No victim is ever drawn from that region, whichever policy is in use.

Top module: `way_victim_sel`

## Requirements
- R1: A request with `fill_req` high at a rising edge produces, after that edge, exactly one cycle with either `victim_valid` or `no_victim` high, never both. `victim_way` holds its value until the next result. Both flags stay low after edges where `fill_req` is low.
- R2: After synchronous reset (`rst` high at an edge), `victim_valid`, `no_victim` and `victim_way` are all 0, and the round-robin pointer is at way 0.
- R3: With `repl_mode` = 0 (round-robin), successive requests return consecutive way numbers, starting at the current pointer.
- R4: In round-robin mode, the request that returns way 63 moves the pointer to L, not to way 0.
- R5: With lock base L (values above 64 count as 64), no returned way is below L, in either mode.
- R6: When L is raised above the round-robin pointer, the pointer is moved up to L once L has been held for one cycle. Lowering L afterwards does not move the pointer back down.
- R7: With `repl_mode` = 1 (pseudo-random), the returned way is L + (S mod (64 - L)). S is the 7-bit LFSR state at the request edge.
- R8: The LFSR resets to 7'h01 and steps at every edge that is not in reset, whether or not a request is made. The next state is {S[5:0], S[6]^S[5]}, so S is never zero.
- R9: When L is 64 or more, a request raises `no_victim` and `victim_valid` stays low.
- R10: The round-robin pointer does not move on idle cycles or on pseudo-random requests.
- R11: The policy is taken from `repl_mode` at each request edge, so the two modes can be mixed freely from one request to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| repl_mode | input | 1 | 0 = round-robin, 1 = pseudo-random |
| lock_base | input | 7 | Number of locked low ways (L); values above 64 count as 64 |
| fill_req | input | 1 | One-cycle strobe asking for a victim |
| victim_valid | output | 1 | High for the one cycle after a request that found a victim |
| no_victim | output | 1 | High for the one cycle after a request made while all ways are locked |
| victim_way | output | 6 | Selected victim way index |

## Verification
Long runs of round-robin requests with L at 0 and with L non-zero show whether the pointer wraps to L or to 0. Raising and then lowering L between requests shows the difference between a clamp that sticks and one that is only applied at use. Pseudo-random requests at several values of L, with idle gaps of different lengths between them, separate a free-running generator from one that steps only on requests, and also test the fold into the unlocked range. Interleaving the two modes shows that random requests leave the round-robin pointer where it was.

// File: rtl/wvs_pkg.sv
package wvs_pkg;
    parameter int unsigned WAYS   = 64;
    parameter int unsigned LFSR_W = 7;
    localparam int unsigned WAY_W  = $clog2(WAYS);
    localparam int unsigned LOCK_W = WAY_W + 1;

    typedef enum logic {
        REPL_ROUND_ROBIN = 1'b0,
        REPL_RANDOM      = 1'b1
    } repl_mode_e;

    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [LOCK_W-1:0] lock_t;
    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef struct packed {
        logic valid;
        logic none;
        way_t way;
    } victim_s;

    function automatic lock_t sat_lock(input lock_t raw);
        return (raw > LOCK_W'(WAYS)) ? LOCK_W'(WAYS) : raw;
    endfunction

    function automatic way_t rr_next(input way_t cur, input lock_t base);
        return (cur == WAY_W'(WAYS - 1)) ? base[WAY_W-1:0] : cur + WAY_W'(1);
    endfunction

    function automatic lfsr_t lfsr_step(input lfsr_t s);
        return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
    endfunction
endpackage

// File: rtl/wvs_lfsr.sv
module wvs_lfsr
    import wvs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output lfsr_t state
);
    always_ff @(posedge clk) begin
        if (rst) state <= LFSR_W'(1);
        else     state <= lfsr_step(state);
    end
endmodule

// File: rtl/wvs_rr_ptr.sv
module wvs_rr_ptr
    import wvs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lock_t lock,
    input  logic  advance,
    output way_t  eff_way
);
    way_t ptr_q;
    logic all_locked;

    assign all_locked = (lock == LOCK_W'(WAYS));
    // pointer below the locked boundary is read as the boundary itself
    assign eff_way = (LOCK_W'(ptr_q) < lock) ? lock[WAY_W-1:0] : ptr_q;

    always_ff @(posedge clk) begin
        if (rst)             ptr_q <= '0;
        else if (all_locked) ptr_q <= ptr_q;
        else if (advance)    ptr_q <= rr_next(eff_way, lock);
        else                 ptr_q <= eff_way;
    end
endmodule

// File: rtl/wvs_rand_fold.sv
module wvs_rand_fold
    import wvs_pkg::*;
(
    input  lfsr_t rnd,
    input  lock_t lock,
    output way_t  way
);
    lock_t span;
    lfsr_t divisor;
    lfsr_t rem;

    assign span    = LOCK_W'(WAYS) - lock;
    assign divisor = (span == '0) ? LFSR_W'(1) : LFSR_W'(span);
    assign rem     = rnd % divisor;
    assign way     = lock[WAY_W-1:0] + WAY_W'(rem);
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
    import wvs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             repl_mode,
    input  logic [LOCK_W-1:0] lock_base,
    input  logic             fill_req,
    output logic             victim_valid,
    output logic             no_victim,
    output logic [WAY_W-1:0] victim_way
);
    repl_mode_e mode;
    lock_t      lock_s;
    lfsr_t      lfsr_q;
    way_t       rr_way;
    way_t       rnd_way;
    logic       rr_adv;
    logic       all_locked;
    victim_s    pick;
    victim_s    out_q;

    assign mode       = repl_mode_e'(repl_mode);
    assign lock_s     = sat_lock(lock_base);
    assign all_locked = (lock_s == LOCK_W'(WAYS));
    assign rr_adv     = fill_req && (mode == REPL_ROUND_ROBIN);

    wvs_lfsr u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .state (lfsr_q)
    );

    wvs_rr_ptr u_rr (
        .clk     (clk),
        .rst     (rst),
        .lock    (lock_s),
        .advance (rr_adv),
        .eff_way (rr_way)
    );

    wvs_rand_fold u_fold (
        .rnd  (lfsr_q),
        .lock (lock_s),
        .way  (rnd_way)
    );

    always_comb begin
        pick.valid = fill_req && !all_locked;
        pick.none  = fill_req && all_locked;
        pick.way   = (mode == REPL_RANDOM) ? rnd_way : rr_way;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= pick.valid;
            out_q.none  <= pick.none;
            if (pick.valid) out_q.way <= pick.way;
        end
    end

    assign victim_valid = out_q.valid;
    assign no_victim    = out_q.none;
    assign victim_way   = out_q.way;
endmodule

// File: rtl/wvs_checker.sv
module wvs_checker
    import wvs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [LOCK_W-1:0] lock_base,
    input logic              fill_req,
    input logic              victim_valid,
    input logic              no_victim,
    input logic [WAY_W-1:0]  victim_way,
    input logic [LFSR_W-1:0] lfsr_state
);
    p_one_result_r1: assert property (@(posedge clk) disable iff (rst)
        fill_req |=> (victim_valid ^ no_victim));

    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !fill_req |=> (!victim_valid && !no_victim));

    p_not_locked_r5: assert property (@(posedge clk) disable iff (rst)
        victim_valid |-> ({1'b0, victim_way} >= sat_lock($past(lock_base))));

    p_all_locked_r9: assert property (@(posedge clk) disable iff (rst)
        (fill_req && (lock_base >= LOCK_W'(WAYS))) |=> (no_victim && !victim_valid));

    p_lfsr_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != '0);

    p_lfsr_moves_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (lfsr_state != $past(lfsr_state)));
endmodule

bind way_victim_sel wvs_checker u_wvs_checker (
    .clk          (clk),
    .rst          (rst),
    .lock_base    (lock_base),
    .fill_req     (fill_req),
    .victim_valid (victim_valid),
    .no_victim    (no_victim),
    .victim_way   (victim_way),
    .lfsr_state   (lfsr_q)
);

// File: tb/way_victim_sel_tb_top.sv
module way_victim_sel_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       repl_mode = 1'b0;
    logic [6:0] lock_base = '0;
    logic       fill_req = 1'b0;
    logic       victim_valid;
    logic       no_victim;
    logic [5:0] victim_way;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    int   exp_rr = 0;     // bench model of the round-robin pointer
    int   cur_l  = 0;     // saturated lock base in force
    logic [6:0] m_lfsr;   // bench model of the random source

    always #4 clk = ~clk;

    way_victim_sel dut_i (
        .clk          (clk),
        .rst          (rst),
        .repl_mode    (repl_mode),
        .lock_base    (lock_base),
        .fill_req     (fill_req),
        .victim_valid (victim_valid),
        .no_victim    (no_victim),
        .victim_way   (victim_way)
    );

    // R8: generator rule as stated in the requirement
    always @(posedge clk) begin
        if (rst) m_lfsr <= 7'h01;
        else     m_lfsr <= {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_lock(input int l);
        @(negedge clk);
        lock_base = 7'(l);
        @(negedge clk);
        cur_l = (l > 64) ? 64 : l;
        if (cur_l < 64 && exp_rr < cur_l) exp_rr = cur_l;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one request; expected result computed from the requirements
    task automatic fill(input bit md, input string req);
        int exp_way;
        bit exp_none;
        @(negedge clk);
        repl_mode = md;
        fill_req  = 1'b1;
        exp_none  = (cur_l >= 64);
        exp_way   = -1;
        if (!exp_none) begin
            if (md) begin
                exp_way = cur_l + (int'(m_lfsr) % (64 - cur_l));
            end else begin
                exp_way = (exp_rr < cur_l) ? cur_l : exp_rr;
                exp_rr  = (exp_way == 63) ? cur_l : exp_way + 1;
            end
        end
        @(negedge clk);
        fill_req = 1'b0;
        chk(victim_valid == !exp_none, req, victim_valid, !exp_none);
        chk(no_victim == exp_none, req, no_victim, exp_none);
        if (!exp_none) chk(int'(victim_way) == exp_way, req, victim_way, exp_way);
        @(negedge clk);
        chk(!victim_valid && !no_victim, "R1", victim_valid | no_victim, 0);
    endtask

    task automatic t_reset;
        chk(victim_valid == 0, "R2", victim_valid, 0);
        chk(no_victim == 0, "R2", no_victim, 0);
        chk(victim_way == 0, "R2", victim_way, 0);
        fill(0, "R2");
    endtask

    task automatic t_rr_sequence;
        for (int i = 0; i < 5; i++) fill(0, "R3");
    endtask

    task automatic t_rr_wrap_to_base;
        set_lock(5);
        while (exp_rr != 63) fill(0, "R4");
        fill(0, "R4");   // returns 63
        fill(0, "R4");   // must return 5
    endtask

    task automatic t_clamp;
        set_lock(0);
        while (exp_rr != 20) fill(0, "R6");
        set_lock(40);
        set_lock(10);
        fill(0, "R6");   // expects 40
        fill(0, "R6");
    endtask

    task automatic t_random;
        set_lock(0);
        for (int i = 0; i < 6; i++) fill(1, "R7");
        set_lock(40);
        for (int i = 0; i < 6; i++) fill(1, "R5");
        set_lock(63);
        for (int i = 0; i < 3; i++) fill(1, "R7");
    endtask

    task automatic t_free_run;
        set_lock(3);
        for (int i = 1; i < 5; i++) begin
            idle(i);
            fill(1, "R8");
        end
    endtask

    task automatic t_all_locked;
        set_lock(64);
        fill(0, "R9");
        fill(1, "R9");
        set_lock(100);
        fill(0, "R9");
    endtask

    task automatic t_rr_hold;
        set_lock(12);
        fill(0, "R10");
        fill(1, "R10");
        fill(1, "R10");
        idle(7);
        fill(0, "R10");
    endtask

    task automatic t_mode_mix;
        set_lock(50);
        for (int i = 0; i < 8; i++) fill(i[0], "R11");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rr_sequence();
        t_rr_wrap_to_base();
        t_clamp();
        t_random();
        t_free_run();
        t_all_locked();
        t_rr_hold();
        t_mode_mix();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule